// File: doc/BRIEF.md
# Register Access Width Adapter

This block sits between a processor port that issues 1-, 2- and 4-byte big-endian register accesses and a peripheral register space in which every register has one fixed native width. A width table holds one entry for each 4-byte group of offsets. It tells the adapter how to translate each request into accesses the register space accepts, one per clock. There are three cases. When the request matches the native width, it passes through unchanged. When the request is narrower than the register, a read takes the addressed lane out of one native read. A narrow write becomes a read of the native register, a merge of the new lane, and a write-back. When the request is wider than the register, it is split into consecutive native accesses at rising addresses, and the most significant part goes first.

The processor side uses a request/ready handshake. The adapter captures a request when it is idle. It then drives the whole back-end sequence on consecutive cycles and raises ready for one cycle with the assembled read data. Offsets in the upper half of the 1 KiB window are not backed: reads there return zero, writes there are dropped, and neither produces a back-end access. Decoding of the registers behind the back-end port belongs to the register space, not to this block.

Top module: `reg_width_adapter`

## Requirements
- R1: Offsets 0x200 to 0x3FF are unbacked. A request there makes no back-end access. Ready rises in the cycle after acceptance, and a read returns 0.
- R2: The native width comes from a 2-bit table entry indexed by offset bits 8:2. The codes are 1 for byte, 2 for halfword and 3 for word. Code 0 marks an unused group, and it is handled as byte width. In the default table, offset bits 6:5 select byte (0), halfword (1), word (2) or unused (3).
- R3: A request whose size equals the native width makes exactly one back-end access of that width at the same offset. Write data passes unchanged and read data returns unchanged.
- R4: A read narrower than the register makes one native read at the register's aligned offset. It returns the addressed lane in big-endian order: byte k of a word sits in bits 31-8k down to 24-8k.
- R5: A write narrower than the register makes a native read and then a native write at the register's aligned offset, on two consecutive cycles. The written value is the read value with only the addressed big-endian lane replaced.
- R6: A request wider than the register is split into S/N accesses of width N at ascending offsets, one per cycle. The first access carries the most significant part. Read parts are assembled in the same order.
- R7: Offset bit 0 is ignored for halfword requests and bits 1:0 for word requests. Size code 0 is byte, 1 is halfword, and 2 or 3 is word. Back-end size codes are 0 byte, 1 halfword, 2 word.
- R8: A request is accepted only when the adapter is idle. Its first back-end access occurs in the next cycle. Ready is a one-cycle pulse in the cycle after the last access. Changes to request fields after acceptance do not alter the running sequence.
- R9: While reset is applied and after it, ready and the back-end valid are low until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present; held until ready |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqSize | input | 2 | Request size code |
| reqOff | input | 10 | Byte offset within the window |
| reqWdata | input | 32 | Write data, right-aligned |
| reqReady | output | 1 | One-cycle completion pulse |
| rspRdata | output | 32 | Read data, right-aligned, valid with ready |
| beValid | output | 1 | Back-end access this cycle |
| beWrite | output | 1 | Back-end access is a write |
| beSize | output | 2 | Back-end access width code |
| beAddr | output | 10 | Back-end offset |
| beWdata | output | 32 | Back-end write data, right-aligned |
| beRdata | input | 32 | Back-end read data, same cycle, right-aligned |

## Verification
The assertions assume that the register space answers every access in the same cycle it is issued. They also assume that the processor holds its request until ready and does not start a second one before ready drops. The bench keeps to this with a byte-array model that answers combinationally, and it issues each request only once the adapter is idle. Both R8 and the assertions treat mid-sequence changes to the request fields as don't-care inputs. The bench changes those fields on purpose during one split access and checks that the back-end sequence is unaffected.

// File: rtl/wadapt_pkg.sv
package wadapt_pkg;

  localparam int OFFS_W     = 10;
  localparam int DATA_W     = 32;
  localparam int MAP_GROUPS = 2 ** (OFFS_W - 3);

  typedef enum logic [1:0] {
    W_NONE = 2'd0,
    W_BYTE = 2'd1,
    W_HALF = 2'd2,
    W_WORD = 2'd3
  } widthCode_e;

  typedef struct packed {
    logic       load;
    logic       issue;
    logic       beWr;
    logic       wide;
    logic [1:0] idx;
    logic [1:0] lgNat;
    logic       done;
  } ctlStrobe_t;

  function automatic logic [2*MAP_GROUPS-1:0] defaultMap();
    logic [2*MAP_GROUPS-1:0] m;
    m = '0;
    for (int g = 0; g < MAP_GROUPS; g++) begin
      case (g[4:3])
        2'd0:    m[2*g +: 2] = W_BYTE;
        2'd1:    m[2*g +: 2] = W_HALF;
        2'd2:    m[2*g +: 2] = W_WORD;
        default: m[2*g +: 2] = W_NONE;
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/wadapt_ctrl.sv
module wadapt_ctrl
  import wadapt_pkg::*;
#(
  parameter logic [2*MAP_GROUPS-1:0] WIDTH_MAP = defaultMap()
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [1:0] reqSize,
  input  logic [7:0] reqOffHi,
  output ctlStrobe_t ctl,
  output logic       reqReady
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_e;

  state_e     state;
  logic [1:0] idxR, lastIdxR, lgNatR;
  logic       wideR, rmwR, wrR;

  widthCode_e code;
  logic [1:0] lgReq, lgN;
  logic       accept, oob, goWide, goRmw;
  logic [2:0] parts;

  assign accept = (state == S_IDLE) && reqValid;
  assign oob    = reqOffHi[7];
  assign code   = widthCode_e'(WIDTH_MAP[{reqOffHi[6:0], 1'b0} +: 2]);
  assign lgReq  = (reqSize == 2'd0) ? 2'd0 : (reqSize == 2'd1) ? 2'd1 : 2'd2;
  assign lgN    = (code == W_WORD) ? 2'd2 : (code == W_HALF) ? 2'd1 : 2'd0;
  assign goWide = lgReq > lgN;
  assign goRmw  = reqWrite && (lgReq < lgN);
  assign parts  = 3'd1 << (lgReq - lgN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      idxR     <= '0;
      lastIdxR <= '0;
      lgNatR   <= '0;
      wideR    <= 1'b0;
      rmwR     <= 1'b0;
      wrR      <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          idxR   <= '0;
          lgNatR <= lgN;
          wideR  <= goWide;
          rmwR   <= goRmw;
          wrR    <= reqWrite;
          if (goWide)     lastIdxR <= 2'(parts - 3'd1);
          else if (goRmw) lastIdxR <= 2'd1;
          else            lastIdxR <= 2'd0;
          state <= oob ? S_DONE : S_RUN;
        end
        S_RUN: begin
          if (idxR == lastIdxR) state <= S_DONE;
          else                  idxR  <= idxR + 2'd1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load  = accept;
    ctl.issue = (state == S_RUN);
    ctl.beWr  = (state == S_RUN) && wrR && (!rmwR || idxR == 2'd1);
    ctl.wide  = wideR;
    ctl.idx   = idxR;
    ctl.lgNat = lgNatR;
    ctl.done  = (state == S_DONE);
  end

  assign reqReady = ctl.done;

  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> !reqReady);

  a_r1_oob_silent: assert property (@(posedge clk) disable iff (!rstN)
    (accept && oob) |=> (!ctl.issue && reqReady));

  a_r5_rmw_pair: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.issue && rmwR && !ctl.beWr) |=> (ctl.issue && ctl.beWr));

  a_r8_first_access: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !oob) |=> ctl.issue);

endmodule

// File: rtl/wadapt_dp.sv
module wadapt_dp
  import wadapt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [1:0]        reqSize,
  input  logic [OFFS_W-1:0] reqOff,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] beRdata,
  output logic              beValid,
  output logic              beWrite,
  output logic [1:0]        beSize,
  output logic [OFFS_W-1:0] beAddr,
  output logic [DATA_W-1:0] beWdata,
  output logic [DATA_W-1:0] rspRdata
);

  localparam logic [DATA_W-1:0] ONES = '1;

  logic [OFFS_W-1:0] offR;
  logic [1:0]        lgS;
  logic [DATA_W-1:0] wdR, holdR, accR;

  logic [1:0]        lgReq, byteOff, lastIdx;
  logic [2:0]        nBytes, sBytes, parts;
  logic [5:0]        nBits, sBits, shB, wShift;
  logic [DATA_W-1:0] nMask, sMask, extract, merged, rdNat;
  logic [OFFS_W-1:0] natBase, subAddr, alignMask;

  assign lgReq     = (reqSize == 2'd0) ? 2'd0 : (reqSize == 2'd1) ? 2'd1 : 2'd2;
  assign alignMask = ~(OFFS_W'(3'd1 << lgReq) - OFFS_W'(1));

  assign nBytes  = 3'd1 << ctl.lgNat;
  assign sBytes  = 3'd1 << lgS;
  assign nBits   = 6'd8 << ctl.lgNat;
  assign sBits   = 6'd8 << lgS;
  assign nMask   = ~(ONES << nBits);
  assign sMask   = ~(ONES << sBits);
  assign natBase = offR & ~(OFFS_W'(nBytes) - OFFS_W'(1));
  assign subAddr = offR + (OFFS_W'(ctl.idx) << ctl.lgNat);
  assign byteOff = offR[1:0] & 2'(nBytes - 3'd1);
  assign shB     = {3'(nBytes - sBytes - {1'b0, byteOff}), 3'b000};
  assign parts   = 3'd1 << (lgS - ctl.lgNat);
  assign lastIdx = 2'(parts - 3'd1);
  assign wShift  = 6'(lastIdx - ctl.idx) << (3'd3 + {1'b0, ctl.lgNat});

  assign rdNat   = beRdata & nMask;
  assign extract = (rdNat >> shB) & sMask;
  assign merged  = (holdR & ~(sMask << shB)) | ((wdR & sMask) << shB);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offR  <= '0;
      lgS   <= '0;
      wdR   <= '0;
      holdR <= '0;
      accR  <= '0;
    end else if (ctl.load) begin
      offR  <= reqOff & alignMask;
      lgS   <= lgReq;
      wdR   <= reqWdata;
      accR  <= '0;
    end else if (ctl.issue && !ctl.beWr) begin
      holdR <= rdNat;
      accR  <= ctl.wide ? ((accR << nBits) | rdNat) : extract;
    end
  end

  assign beValid  = ctl.issue;
  assign beWrite  = ctl.beWr;
  assign beSize   = ctl.lgNat;
  assign beAddr   = ctl.wide ? subAddr : natBase;
  assign beWdata  = ctl.wide ? ((wdR >> wShift) & nMask) : (merged & nMask);
  assign rspRdata = accR;

  a_r1_backed_only: assert property (@(posedge clk) disable iff (!rstN)
    beValid |-> !beAddr[OFFS_W-1]);

  a_r4_native_aligned: assert property (@(posedge clk) disable iff (!rstN)
    beValid |-> ((beAddr & (OFFS_W'(nBytes) - OFFS_W'(1))) == '0));

  a_r6_ascending: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.issue && ctl.wide && ctl.idx != 2'd0) |->
      (beAddr == $past(beAddr) + OFFS_W'(nBytes)));

endmodule

// File: rtl/reg_width_adapter.sv
module reg_width_adapter
  import wadapt_pkg::*;
#(
  parameter logic [2*MAP_GROUPS-1:0] WIDTH_MAP = defaultMap()
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [OFFS_W-1:0] reqOff,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic [DATA_W-1:0] rspRdata,
  output logic              beValid,
  output logic              beWrite,
  output logic [1:0]        beSize,
  output logic [OFFS_W-1:0] beAddr,
  output logic [DATA_W-1:0] beWdata,
  input  logic [DATA_W-1:0] beRdata
);

  ctlStrobe_t ctl;

  wadapt_ctrl #(.WIDTH_MAP(WIDTH_MAP)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqSize  (reqSize),
    .reqOffHi (reqOff[OFFS_W-1:2]),
    .ctl      (ctl),
    .reqReady (reqReady)
  );

  wadapt_dp i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqSize  (reqSize),
    .reqOff   (reqOff),
    .reqWdata (reqWdata),
    .beRdata  (beRdata),
    .beValid  (beValid),
    .beWrite  (beWrite),
    .beSize   (beSize),
    .beAddr   (beAddr),
    .beWdata  (beWdata),
    .rspRdata (rspRdata)
  );

endmodule

// File: tb/test_reg_width_adapter.sv
`timescale 1ns/1ps
module test_reg_width_adapter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]  reqSize = '0;
  logic [9:0]  reqOff = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady, beValid, beWrite;
  logic [31:0] rspRdata, beWdata, beRdata;
  logic [1:0]  beSize;
  logic [9:0]  beAddr;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  logic [7:0] mem [0:511];

  always #2.5 clk = ~clk;

  reg_width_adapter i_reg_width_adapter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqOff(reqOff), .reqWdata(reqWdata),
    .reqReady(reqReady), .rspRdata(rspRdata), .beValid(beValid),
    .beWrite(beWrite), .beSize(beSize), .beAddr(beAddr),
    .beWdata(beWdata), .beRdata(beRdata)
  );

  // Back-end register space model: byte array, big-endian, same-cycle answer
  always_comb begin
    case (beSize)
      2'd0:    beRdata = {24'h0, mem[beAddr[8:0]]};
      2'd1:    beRdata = {16'h0, mem[beAddr[8:0]], mem[9'(beAddr[8:0] + 9'd1)]};
      default: beRdata = {mem[beAddr[8:0]], mem[9'(beAddr[8:0] + 9'd1)],
                          mem[9'(beAddr[8:0] + 9'd2)], mem[9'(beAddr[8:0] + 9'd3)]};
    endcase
  end

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 512; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (beValid && beWrite) begin
      for (int j = 0; j < (1 << beSize); j++)
        mem[9'(beAddr[8:0] + 9'(j))] <= beWdata[8*((1 << beSize) - 1 - j) +: 8];
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Native width in bytes per the default table (R2)
  function automatic int natBytes(int off);
    case ((off >> 5) & 3)
      1: return 2;
      2: return 4;
      default: return 1;
    endcase
  endfunction

  task automatic doReq(string req, bit w, logic [1:0] sz, logic [9:0] off,
                       logic [31:0] d, bit scramble = 0);
    int S, N, a, nOps, x, na;
    int eAddr [4];
    bit eWr [4];
    logic [31:0] eData [4];
    logic [31:0] expRd;
    S = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    a = int'(off) & ~(S - 1);
    N = natBytes(a);
    nOps = 0;
    if (a < 'h200) begin
      if (S == N) begin
        eAddr[0] = a; eWr[0] = w; nOps = 1;
      end else if (S < N) begin
        na = a & ~(N - 1);
        eAddr[0] = na; eWr[0] = 0; nOps = 1;
        if (w) begin eAddr[1] = na; eWr[1] = 1; nOps = 2; end
      end else begin
        for (int k = 0; k < S / N; k++) begin eAddr[k] = a + k * N; eWr[k] = w; end
        nOps = S / N;
      end
    end else N = 0;
    expRd = '0;
    if (a < 'h200) for (int j = 0; j < S; j++) expRd = (expRd << 8) | 32'(mem[a + j]);
    for (int k = 0; k < nOps; k++) begin
      eData[k] = '0;
      for (int j = 0; j < N; j++) begin
        x = eAddr[k] + j;
        eData[k] = eData[k] << 8;
        if (x >= a && x < a + S) eData[k][7:0] = d[8*(S - 1 - (x - a)) +: 8];
        else eData[k][7:0] = mem[x];
      end
    end
    reqValid = 1; reqWrite = w; reqSize = sz; reqOff = off; reqWdata = d;
    for (int k = 0; k < nOps; k++) begin
      @(negedge clk);
      chk({req, " beValid"}, 32'(beValid), 32'd1);
      chk({req, " beAddr"},  32'(beAddr), 32'(eAddr[k]));
      chk({req, " beSize"},  32'(beSize), (N == 4) ? 32'd2 : (N == 2) ? 32'd1 : 32'd0);
      chk({req, " beWrite"}, 32'(beWrite), 32'(eWr[k]));
      chk({req, " ready low while busy"}, 32'(reqReady), 32'd0);
      if (eWr[k]) chk({req, " beWdata"}, beWdata, eData[k]);
      if (scramble && k == 0) begin
        reqOff = off ^ 10'h0F0; reqSize = 2'd0; reqWdata = ~d; reqWrite = ~w;
      end
    end
    @(negedge clk);
    chk({req, " ready pulse"}, 32'(reqReady), 32'd1);
    chk({req, " no access at ready"}, 32'(beValid), 32'd0);
    if (!w) chk({req, " read data"}, rspRdata, expRd);
    reqValid = 0;
    @(negedge clk);
    chk({req, " ready drops"}, 32'(reqReady), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset ready", 32'(reqReady), 32'd0);
    chk("R9 reset beValid", 32'(beValid), 32'd0);
    rstN = 1;
    @(negedge clk);
    chk("R9 idle beValid", 32'(beValid), 32'd0);

    doReq("R3 byte read byte reg", 0, 2'd0, 10'h005, 0);
    doReq("R3 half write half reg", 1, 2'd1, 10'h022, 32'h0000_BEEF);
    doReq("R3 half read back", 0, 2'd1, 10'h022, 0);
    doReq("R3 word write word reg", 1, 2'd2, 10'h044, 32'hCAFE_F00D);
    doReq("R3 word read back", 0, 2'd2, 10'h044, 0);

    doReq("R4 byte read even of half", 0, 2'd0, 10'h020, 0);
    doReq("R4 byte read odd of half", 0, 2'd0, 10'h021, 0);
    doReq("R4 byte read lane3 of word", 0, 2'd0, 10'h047, 0);
    doReq("R4 byte read lane0 of word", 0, 2'd0, 10'h044, 0);
    doReq("R4 half read lower of word", 0, 2'd1, 10'h046, 0);

    doReq("R5 byte write word reg", 1, 2'd0, 10'h043, 32'h0000_00A5);
    doReq("R5 word read after merge", 0, 2'd2, 10'h040, 0);
    doReq("R5 half write upper of word", 1, 2'd1, 10'h048, 32'h0000_1234);
    doReq("R5 half write lower of word", 1, 2'd1, 10'h04A, 32'h0000_5678);
    doReq("R5 word read merged halves", 0, 2'd2, 10'h048, 0);
    doReq("R5 byte write even of half", 1, 2'd0, 10'h024, 32'h0000_0077);
    doReq("R5 half read after merge", 0, 2'd1, 10'h024, 0);

    doReq("R6 half read byte regs", 0, 2'd1, 10'h008, 0);
    doReq("R6 word read byte regs", 0, 2'd2, 10'h00C, 0);
    doReq("R6 word write half regs", 1, 2'd2, 10'h028, 32'h89AB_CDEF);
    doReq("R6 word read half regs", 0, 2'd2, 10'h028, 0);
    doReq("R6 half write byte regs", 1, 2'd1, 10'h012, 32'h0000_C3D4);
    doReq("R2 word write unused group", 1, 2'd2, 10'h064, 32'h1122_3344);
    doReq("R2 word read unused group", 0, 2'd2, 10'h064, 0);
    doReq("R2 repeat map word group", 0, 2'd0, 10'h0C5, 0);
    doReq("R2 repeat map half group", 1, 2'd2, 10'h1A0, 32'h0BAD_F00D);

    doReq("R7 half misaligned", 0, 2'd1, 10'h023, 0);
    doReq("R7 word misaligned", 1, 2'd2, 10'h04E, 32'hDEAD_0001);
    doReq("R7 word misaligned read", 0, 2'd2, 10'h04D, 0);
    doReq("R7 size code 3", 0, 2'd3, 10'h052, 0);

    doReq("R1 read unbacked", 0, 2'd2, 10'h210, 0);
    doReq("R1 write unbacked", 1, 2'd2, 10'h300, 32'hFFFF_FFFF);
    doReq("R1 byte read unbacked top", 0, 2'd0, 10'h3FF, 0);
    doReq("R1 backing intact", 0, 2'd2, 10'h100, 0);

    doReq("R8 fields changed mid split", 0, 2'd2, 10'h010, 0, 1);
    doReq("R8 write fields changed mid split", 1, 2'd2, 10'h030, 32'h5566_7788, 1);
    doReq("R8 read back after changed write", 0, 2'd2, 10'h030, 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule